// File: doc/BRIEF.md
# Queued SPI Slave Engine

This block is the receive-and-reply half of a queued serial port. An external SPI master owns the serial clock and an active-low select line. The block answers from a small transmit RAM and stores what it hears in a receive RAM. Both RAMs are indexed by the same working queue pointer, which moves forward one address per completed word. The word length is a single setting shared by every word in the queue.

A host processor sets up the block through a flat register and RAM port. It writes the control byte, loads transmit words, and sets the start and end queue addresses. Once the transfers are over, it reads back the received words, the address of the last completed word and a done flag.

The select line may stay low across many words or toggle between them; the queue advances the same way in both cases. A word cut short by the select line rising is discarded and retried at the same address. Serial inputs pass through two-flop synchronizers, so the system clock must run at four or more times the serial clock.

Top module: `qspi_slave_engine`

## Requirements
- R1: After reset the control register, the working pointer, the completed pointer and the done flag all read 0, and `spi_miso_oe` is low.
- R2: The engine shifts only when control bit 0 (enable) is 1 and control bit 1 (master select) is 0. In any other case SCK pulses are ignored: no receive word is written and the working pointer does not move.
- R3: When the select line falls, shifting starts at the working pointer. Register index 1 holds that pointer and is loaded by a host write. The received word is written to receive RAM at that address. The transmit word at the same address is sent MSB first on MISO.
- R4: Control bits [7:4] set the word length for every word. A value of 0 means 16 bits; a value of n from 1 to 15 means n bits. Words shorter than 16 bits use, and fill, the low n bits of a RAM word.
- R5: When a word completes, the completed pointer (register index 3) takes the address of that word, the working pointer increments, and the next transmit word is loaded. This lets words follow back to back while the select line stays low.
- R6: If the select line rises before a word completes, nothing is written and the working pointer does not move. The next assertion of the select line restarts at the same address.
- R7: The working pointer carries over from one select assertion to the next. A host write to register index 1 in between replaces it.
- R8: When the word at the end pointer (register index 2) completes, status bit 0 (register index 4) goes to 1. After that, no further words are taken until the host writes register index 1, which clears the flag.
- R9: Control bit 2 (clock polarity) and control bit 3 (clock phase) choose the edges. With phase 0, MOSI is sampled on the first SCK edge after idle and MISO changes on the second. With phase 1 the roles are reversed. All four combinations give correct data.
- R10: `spi_miso_oe` is high only while the select line is low and the engine is enabled in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | PTR_W+2 | Host address: bits [PTR_W+1:PTR_W] select registers (0), transmit RAM (1) or receive RAM (2); the low bits give the register index or RAM address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational from host_addr |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data in |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for MISO |

## Verification
The bench sends a word at the end address while the engine is done. A design that kept advancing would overwrite the next receive word and move the completed pointer. It also cuts a word off after five bits. A design that advanced anyway would skip an address, so the retried word would land one slot too far and return the wrong transmit data. Three 16-bit words are sent back to back under one select assertion with phase 1, and 12-bit words are sent with polarity 1. These catch a next word that is loaded late or shifted one bit off, and edges that are swapped. The bench also sends a full word while the engine is disabled and while master select is set, to confirm the pointer stays put.

// File: rtl/qspi_slv_pkg.sv
package qspi_slv_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 5;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic [3:0] wlen;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } ctrl_t;

  localparam logic [1:0] RGN_REG = 2'd0;
  localparam logic [1:0] RGN_TX  = 2'd1;
  localparam logic [1:0] RGN_RX  = 2'd2;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_NEWQ = 3'd1;
  localparam logic [2:0] REG_ENDQ = 3'd2;
  localparam logic [2:0] REG_CPTQ = 3'd3;
  localparam logic [2:0] REG_STAT = 3'd4;

  function automatic logic [CNT_W-1:0] wlen_bits(input logic [3:0] code);
    return (code == 4'd0) ? CNT_W'(WORD_W) : {1'b0, code};
  endfunction
endpackage

// File: rtl/qspi_slv_sync.sv
module qspi_slv_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d[g];
        sync_q <= meta_q;
      end
    end
    assign q[g] = sync_q;
  end
endmodule

// File: rtl/qspi_slv_ram.sv
module qspi_slv_ram #(
  parameter int DW  = 16,
  parameter int AW  = 4,
  parameter int NRD = 1
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/qspi_slv_shifter.sv
module qspi_slv_shifter
  import qspi_slv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             ss_n_s,
  input  logic             sck_s,
  input  logic             mosi_s,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [CNT_W-1:0] nbits,
  input  word_t            tx_word,
  output logic             miso_bit,
  output logic             word_done,
  output word_t            rx_word
);
  logic             sck_d_q, ss_d_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  word_t            shreg_q, shreg_d, rxreg_q, rxreg_d, rx_shift;
  logic             miso_q, miso_d, skip_q, skip_d, load_q, load_d;
  logic             sck_rise, sck_fall, lead, trail, samp, drv, run, start;
  logic [CNT_W-1:0] shamt;

  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;
  assign lead     = cpol ? sck_fall : sck_rise;
  assign trail    = cpol ? sck_rise : sck_fall;
  assign samp     = cpha ? trail : lead;
  assign drv      = cpha ? lead : trail;
  assign run      = active & ~ss_n_s;
  assign start    = run & ss_d_q;
  assign rx_shift = {rxreg_q[WORD_W-2:0], mosi_s};
  assign shamt    = CNT_W'(WORD_W) - nbits;

  always_comb begin
    cnt_d     = cnt_q;
    shreg_d   = shreg_q;
    rxreg_d   = rxreg_q;
    miso_d    = miso_q;
    skip_d    = skip_q;
    load_d    = load_q;
    word_done = 1'b0;
    if (!run) begin
      cnt_d  = '0;
      skip_d = 1'b0;
      load_d = 1'b0;
    end else if (start) begin
      cnt_d   = '0;
      rxreg_d = '0;
      skip_d  = 1'b0;
      load_d  = 1'b1;
    end else begin
      if (load_q) begin
        shreg_d = tx_word << shamt;
        load_d  = 1'b0;
      end else if (drv) begin
        if (skip_q) begin
          skip_d = 1'b0;
        end else begin
          miso_d  = shreg_q[WORD_W-1];
          shreg_d = shreg_q << 1;
        end
      end
      if (samp) begin
        if (cnt_q == nbits - 1'b1) begin
          word_done = 1'b1;
          cnt_d     = '0;
          rxreg_d   = '0;
          load_d    = 1'b1;
          skip_d    = ~cpha;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          rxreg_d = rx_shift;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q <= 1'b0;
      ss_d_q  <= 1'b1;
      cnt_q   <= '0;
      shreg_q <= '0;
      rxreg_q <= '0;
      miso_q  <= 1'b0;
      skip_q  <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      sck_d_q <= sck_s;
      ss_d_q  <= ss_n_s;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      rxreg_q <= rxreg_d;
      miso_q  <= miso_d;
      skip_q  <= skip_d;
      load_q  <= load_d;
    end
  end

  assign miso_bit = cpha ? miso_q : shreg_q[WORD_W-1];
  assign rx_word  = rx_shift;

  // R4: the bit counter never reaches the word length
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < nbits));

  // R9: the post-load drive skip exists only for phase 0
  p_skip_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |-> !cpha);

  // R6: select high always leaves the counter at zero
  p_abort_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n_s) |=> (cnt_q == '0));
endmodule

// File: rtl/qspi_slave_engine.sv
module qspi_slave_engine
  import qspi_slv_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [PTR_W+1:0]   host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_rdata,
  input  logic               spi_sck,
  input  logic               spi_mosi,
  input  logic               spi_ss_n,
  output logic               spi_miso,
  output logic               spi_miso_oe
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] pins_s;
  logic             sck_s, mosi_s, ss_n_s;

  qspi_slv_sync #(.W(NSYNC), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_ss_n, spi_mosi, spi_sck}),
    .q     (pins_s)
  );
  assign {ss_n_s, mosi_s, sck_s} = pins_s;

  // host decode
  logic [1:0]       region;
  logic [PTR_W-1:0] idx;
  logic [2:0]       reg_sel;
  logic             reg_wr, ptr_wr, tx_wr;

  assign region  = host_addr[PTR_W+1:PTR_W];
  assign idx     = host_addr[PTR_W-1:0];
  assign reg_sel = idx[2:0];
  assign reg_wr  = host_we && (region == RGN_REG);
  assign ptr_wr  = reg_wr && (reg_sel == REG_NEWQ);
  assign tx_wr   = host_we && (region == RGN_TX);

  // control and pointer state
  ctrl_t            ctrl_q, ctrl_d;
  logic [PTR_W-1:0] wptr_q, wptr_d, endp_q, endp_d, cptr_q, cptr_d;
  logic             done_q, done_d;
  logic             slave_on, active, word_done, miso_bit;
  logic [CNT_W-1:0] nbits;
  word_t            rx_word;

  assign slave_on = ctrl_q.en & ~ctrl_q.master;
  assign active   = slave_on & ~done_q;
  assign nbits    = wlen_bits(ctrl_q.wlen);

  always_comb begin
    ctrl_d = ctrl_q;
    wptr_d = wptr_q;
    endp_d = endp_q;
    cptr_d = cptr_q;
    done_d = done_q;
    if (word_done) begin
      cptr_d = wptr_q;
      if (wptr_q == endp_q) done_d = 1'b1;
      else                  wptr_d = wptr_q + 1'b1;
    end
    if (reg_wr) begin
      case (reg_sel)
        REG_CTRL: ctrl_d = ctrl_t'(host_wdata[7:0]);
        REG_NEWQ: begin
          wptr_d = host_wdata[PTR_W-1:0];
          done_d = 1'b0;
        end
        REG_ENDQ: endp_d = host_wdata[PTR_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      wptr_q <= '0;
      endp_q <= '0;
      cptr_q <= '0;
      done_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      wptr_q <= wptr_d;
      endp_q <= endp_d;
      cptr_q <= cptr_d;
      done_q <= done_d;
    end
  end

  // queue RAMs
  logic [1:0][PTR_W-1:0]  tx_raddr;
  logic [1:0][WORD_W-1:0] tx_rdata;
  logic [0:0][PTR_W-1:0]  rx_raddr;
  logic [0:0][WORD_W-1:0] rx_rdata;

  assign tx_raddr = {wptr_q, idx};
  assign rx_raddr = idx;

  qspi_slv_ram #(.DW(WORD_W), .AW(PTR_W), .NRD(2)) u_tx_ram (
    .clk   (clk),
    .we    (tx_wr),
    .waddr (idx),
    .wdata (host_wdata),
    .raddr (tx_raddr),
    .rdata (tx_rdata)
  );

  qspi_slv_ram #(.DW(WORD_W), .AW(PTR_W), .NRD(1)) u_rx_ram (
    .clk   (clk),
    .we    (word_done),
    .waddr (wptr_q),
    .wdata (rx_word),
    .raddr (rx_raddr),
    .rdata (rx_rdata)
  );

  qspi_slv_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .ss_n_s    (ss_n_s),
    .sck_s     (sck_s),
    .mosi_s    (mosi_s),
    .cpol      (ctrl_q.cpol),
    .cpha      (ctrl_q.cpha),
    .nbits     (nbits),
    .tx_word   (tx_rdata[1]),
    .miso_bit  (miso_bit),
    .word_done (word_done),
    .rx_word   (rx_word)
  );

  assign spi_miso_oe = slave_on & ~ss_n_s;
  assign spi_miso    = spi_miso_oe & miso_bit;

  // host read mux
  always_comb begin
    host_rdata = '0;
    case (region)
      RGN_REG: begin
        case (reg_sel)
          REG_CTRL: host_rdata = {8'h00, ctrl_q};
          REG_NEWQ: host_rdata = WORD_W'(wptr_q);
          REG_ENDQ: host_rdata = WORD_W'(endp_q);
          REG_CPTQ: host_rdata = WORD_W'(cptr_q);
          REG_STAT: host_rdata = WORD_W'(done_q);
          default:  host_rdata = '0;
        endcase
      end
      RGN_TX:  host_rdata = tx_rdata[0];
      RGN_RX:  host_rdata = rx_rdata[0];
      default: host_rdata = '0;
    endcase
  end

  // R5: completed pointer records the address of the finished word
  p_cptr_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !ptr_wr |=> cptr_q == $past(wptr_q));

  // R5: pointer steps by one when the word was not the last
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !ptr_wr && (wptr_q != endp_q) |=> wptr_q == $past(wptr_q) + 1'b1);

  // R6: select rising never moves the pointer
  p_abort_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n_s) && !ptr_wr |=> $stable(wptr_q));

  // R8: once done, the queue is frozen until the host rewrites it
  p_done_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !ptr_wr |=> $stable(wptr_q) && done_q);

  // R2: no word completes unless enabled in slave mode
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_on |-> !word_done);

  // R10: output enable stays low while select is high
  p_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_s |-> !spi_miso_oe);
endmodule

// File: tb/qspi_slave_engine_test.sv
module qspi_slave_engine_test;
  localparam int PTR_W = 4;
  localparam int H     = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_we = 1'b0;
  logic [PTR_W+1:0]  host_addr = '0;
  logic [15:0]       host_wdata = '0;
  logic [15:0]       host_rdata;
  logic              sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic              miso, miso_oe;

  int checks = 0;
  int fails  = 0;
  logic m_cpol = 1'b0, m_cpha = 1'b0;

  always #4 clk = ~clk;

  qspi_slave_engine #(.PTR_W(PTR_W)) uut (
    .clk (clk), .rst_n (rst_n),
    .host_we (host_we), .host_addr (host_addr),
    .host_wdata (host_wdata), .host_rdata (host_rdata),
    .spi_sck (sck), .spi_mosi (mosi), .spi_ss_n (ss_n),
    .spi_miso (miso), .spi_miso_oe (miso_oe)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'hC3A5 ^ (16'(i) * 16'h1111);
  endfunction

  function automatic logic [15:0] mk(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hw(input logic [PTR_W+1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [PTR_W+1:0] a, output logic [15:0] v);
    @(negedge clk);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  function automatic logic [PTR_W+1:0] ra(input int i);
    return {2'd0, PTR_W'(i)};
  endfunction
  function automatic logic [PTR_W+1:0] ta(input int i);
    return {2'd1, PTR_W'(i)};
  endfunction
  function automatic logic [PTR_W+1:0] xa(input int i);
    return {2'd2, PTR_W'(i)};
  endfunction

  task automatic set_mode(input logic cpol, input logic cpha,
                          input logic [3:0] wl, input logic en, input logic mst);
    hw(ra(0), {8'h00, wl, cpha, cpol, mst, en});
    m_cpol = cpol; m_cpha = cpha;
    sck = cpol;
    wt(H);
  endtask

  task automatic ss_low();
    ss_n = 1'b0; wt(H);
  endtask

  task automatic ss_high();
    wt(H); ss_n = 1'b1; wt(2 * H);
  endtask

  task automatic xfer(input logic [15:0] d, input int n, input int stop,
                      output logic [15:0] got);
    got = '0;
    for (int i = 0; i < n && i < stop; i++) begin
      if (!m_cpha) begin
        mosi = d[n-1-i];
        wt(H); sck = ~m_cpol; got = {got[14:0], miso};
        wt(H); sck = m_cpol;
      end else begin
        wt(H); sck = ~m_cpol; mosi = d[n-1-i];
        wt(H); sck = m_cpol; got = {got[14:0], miso};
      end
    end
  endtask

  task automatic one_word(input logic [15:0] d, input int n, output logic [15:0] got);
    ss_low();
    xfer(d, n, n, got);
    ss_high();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    hr(ra(0), v); chk("R1", "ctrl", v, 16'h0);
    hr(ra(1), v); chk("R1", "wptr", v, 16'h0);
    hr(ra(3), v); chk("R1", "cptr", v, 16'h0);
    hr(ra(4), v); chk("R1", "done", v, 16'h0);
    chk("R1", "miso_oe", 16'(miso_oe), 16'h0);
  endtask

  task automatic t_basic();
    logic [15:0] v, got;
    set_mode(1'b0, 1'b0, 4'd8, 1'b1, 1'b0);
    hw(ra(2), 16'd5);
    hw(ra(1), 16'd2);
    ss_low();
    chk("R10", "oe while selected", 16'(miso_oe), 16'h1);
    xfer(16'h003C, 8, 8, got);
    ss_high();
    chk("R10", "oe after deselect", 16'(miso_oe), 16'h0);
    chk("R3", "miso word", got, pat(2) & mk(8));
    hr(xa(2), v); chk("R3", "rx word", v, 16'h003C);
    hr(ra(3), v); chk("R5", "cptr", v, 16'd2);
    hr(ra(1), v); chk("R5", "wptr", v, 16'd3);
  endtask

  task automatic t_burst();
    logic [15:0] v, got;
    set_mode(1'b0, 1'b1, 4'd0, 1'b1, 1'b0);
    ss_low();
    for (int k = 0; k < 3; k++) begin
      xfer(16'h1234 + 16'(k * 16'h0F0F), 16, 16, got);
      chk("R9", "burst miso mode1", got, pat(3 + k));
    end
    ss_high();
    for (int k = 0; k < 3; k++) begin
      hr(xa(3 + k), v);
      chk("R4", "16-bit rx word", v, 16'h1234 + 16'(k * 16'h0F0F));
    end
    hr(ra(4), v); chk("R8", "done set", v, 16'h1);
    hr(ra(3), v); chk("R5", "cptr after burst", v, 16'd5);
    hr(ra(1), v); chk("R8", "wptr at end", v, 16'd5);
  endtask

  task automatic t_done_ignores();
    logic [15:0] v, got;
    one_word(16'hFFFF, 16, got);
    hr(xa(5), v); chk("R8", "rx at end untouched", v, 16'h1234 + 16'h1E1E);
    hr(ra(1), v); chk("R8", "wptr frozen", v, 16'd5);
    hr(ra(4), v); chk("R8", "still done", v, 16'h1);
  endtask

  task automatic t_abort_retry();
    logic [15:0] v, got;
    set_mode(1'b0, 1'b0, 4'd8, 1'b1, 1'b0);
    hw(ra(2), 16'd15);
    hw(ra(1), 16'd8);
    hr(ra(4), v); chk("R8", "done cleared by ptr write", v, 16'h0);
    ss_low();
    xfer(16'h00F0, 8, 5, got);
    ss_high();
    hr(ra(1), v); chk("R6", "wptr after abort", v, 16'd8);
    hr(ra(3), v); chk("R6", "cptr after abort", v, 16'd5);
    one_word(16'h005A, 8, got);
    chk("R6", "retry miso", got, pat(8) & mk(8));
    hr(xa(8), v); chk("R6", "retry rx", v, 16'h005A);
    hr(ra(1), v); chk("R6", "wptr after retry", v, 16'd9);
  endtask

  task automatic t_persist();
    logic [15:0] v, got;
    one_word(16'h0011, 8, got);
    chk("R7", "carried pointer miso", got, pat(9) & mk(8));
    hr(xa(9), v); chk("R7", "carried pointer rx", v, 16'h0011);
    hw(ra(1), 16'd12);
    one_word(16'h0022, 8, got);
    chk("R7", "override miso", got, pat(12) & mk(8));
    hr(xa(12), v); chk("R7", "override rx", v, 16'h0022);
    hr(ra(3), v); chk("R7", "override cptr", v, 16'd12);
  endtask

  task automatic t_modes();
    logic [15:0] v, got;
    set_mode(1'b1, 1'b0, 4'd12, 1'b1, 1'b0);
    hw(ra(1), 16'd0);
    one_word(16'h0ABC, 12, got);
    chk("R9", "mode2 miso", got, pat(0) & mk(12));
    hr(xa(0), v); chk("R9", "mode2 rx", v, 16'h0ABC);
    set_mode(1'b1, 1'b1, 4'd12, 1'b1, 1'b0);
    one_word(16'h0123, 12, got);
    chk("R9", "mode3 miso", got, pat(1) & mk(12));
    hr(xa(1), v); chk("R9", "mode3 rx", v, 16'h0123);
    set_mode(1'b0, 1'b0, 4'd4, 1'b1, 1'b0);
    hw(ra(1), 16'd6);
    one_word(16'h0009, 4, got);
    chk("R4", "4-bit miso", got, pat(6) & mk(4));
    hr(xa(6), v); chk("R4", "4-bit rx", v, 16'h0009);
  endtask

  task automatic t_gated();
    logic [15:0] v, got;
    set_mode(1'b0, 1'b0, 4'd8, 1'b0, 1'b0);
    hw(ra(1), 16'd13);
    ss_low();
    chk("R10", "oe disabled", 16'(miso_oe), 16'h0);
    xfer(16'h0077, 8, 8, got);
    ss_high();
    hr(ra(1), v); chk("R2", "wptr with enable clear", v, 16'd13);
    hr(ra(3), v); chk("R2", "cptr with enable clear", v, 16'd6);
    set_mode(1'b0, 1'b0, 4'd8, 1'b1, 1'b1);
    ss_low();
    chk("R10", "oe master mode", 16'(miso_oe), 16'h0);
    xfer(16'h0066, 8, 8, got);
    ss_high();
    hr(ra(1), v); chk("R2", "wptr with master set", v, 16'd13);
    set_mode(1'b0, 1'b0, 4'd8, 1'b1, 1'b0);
    one_word(16'h0055, 8, got);
    hr(xa(13), v); chk("R2", "rx once re-enabled", v, 16'h0055);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wt(4);
    rst_n = 1'b1;
    wt(2);
    t_reset();
    for (int i = 0; i < 16; i++) hw(ta(i), pat(i));
    t_basic();
    t_burst();
    t_done_ignores();
    t_abort_retry();
    t_persist();
    t_modes();
    t_gated();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule